// File: doc/BRIEF.md
# DMA Request Capture and Conditioning Unit

This block sits in front of a DMA controller's channel logic and conditions its request lines. Four external requests arrive active-low from asynchronous pads. A few internal requests arrive active-high from on-chip peripherals that already run on the system clock. Every line leaves the block as a registered, active-high request together with a pending flag.

Each external line has its own sensitivity select, which picks one of two schemes. In the level scheme the output tracks the asserted state of the line, and the controller waits for the line to deassert. In the edge scheme a falling edge on the pad sets a sticky pending bit, and a one-cycle acknowledge from the controller clears that bit. The select bits are taken from two configuration words. After reset every external line uses the level scheme. Among the internal lines, one display line-trigger request always uses the edge scheme and all the others always use the level scheme.

There is no data stream here, so no valid/ready handshake is involved and there is no back-pressure. The request outputs and the acknowledge inputs are plain control pins. An acknowledge is a single-cycle pulse and is sampled only for a line that is in the edge scheme.

Top module: `dmarq_capture`

## Requirements
- R1: While reset is asserted and on the first clock edge after it is released, every request output and every pending output is 0, and all four external lines use the level scheme.
- R2: The select bit for external line 0 is bit 0 of `sens_cfg_a_i` and for line 1 it is bit 1 of that word. For line 2 it is bit 7 of `sens_cfg_b_i` and for line 3 it is bit 8 of that word. A value of 1 selects the edge scheme and 0 selects the level scheme. All other bits of both words have no effect.
- R3: In the level scheme, `ext_req_o[i]` equals the inverse of `ext_req_ni[i]` as that pin stood three rising clock edges earlier (two synchronizer flops plus the output register), and `ext_pend_o[i]` stays 0.
- R4: In the edge scheme, a high-to-low transition on `ext_req_ni[i]` sets both `ext_pend_o[i]` and `ext_req_o[i]` on the third rising edge after the pin falls. Both stay set after the pin returns high, until an acknowledge arrives.
- R5: In the edge scheme, an `ext_ack_i[i]` pulse with no new falling edge clears the pending bit and the request on the next rising edge. If a new falling edge is detected in the same cycle as the acknowledge, the bit stays set.
- R6: In the level scheme, `ext_ack_i[i]` has no effect on any output.
- R7: When a line's select bit changes, that line's pending bit is 0 on the next rising edge. A switch to the edge scheme while the pin is held low drops the request and captures nothing until a new falling edge.
- R8: Internal level lines are not synchronized. `int_req_o[i]` equals `int_req_i[i]` one rising edge later, `int_pend_o[i]` stays 0, and `int_ack_i[i]` has no effect.
- R9: Internal line `DISP_IDX` (index 2 by default) is fixed to the edge scheme. A low-to-high transition of `int_req_i` on that line sets `int_pend_o` and `int_req_o` for that line on the next rising edge. They stay set until `int_ack_i` clears them.
- R10: In the edge scheme, a pin that stays low after its request has been acknowledged raises no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_req_ni | input | 4 | External request pads, active low, asynchronous |
| sens_cfg_a_i | input | CFG_W | Configuration word holding the select bits of lines 0 and 1 |
| sens_cfg_b_i | input | CFG_W | Configuration word holding the select bits of lines 2 and 3 |
| ext_ack_i | input | 4 | One-cycle acknowledge for each external line |
| int_req_i | input | NUM_INT | Internal peripheral requests, active high, synchronous |
| int_ack_i | input | NUM_INT | One-cycle acknowledge for each internal line |
| ext_req_o | output | 4 | Conditioned external requests, active high, registered |
| ext_pend_o | output | 4 | External edge-capture pending flags |
| int_req_o | output | NUM_INT | Conditioned internal requests, active high, registered |
| int_pend_o | output | NUM_INT | Internal edge-capture pending flags |

## Verification
The assertions assume three things about the inputs. Acknowledges are single-cycle pulses. The configuration words are never unknown after reset. The internal request lines are already synchronous to the clock. The stimulus drives every input on the falling clock edge and releases each acknowledge after exactly one cycle. It changes a select bit only while the affected pad has been steady for several cycles, except where a test deliberately holds a pad low across a switch of scheme. External pads are held low or high for at least four cycles, so every transition passes through the synchronizer before the next one arrives. The one deliberate exception is the collision case, where an acknowledge is timed to meet a newly synchronized falling edge.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

  localparam int NUM_EXT = 4;

  typedef enum logic {
    SENS_LEVEL = 1'b0,
    SENS_EDGE  = 1'b1
  } sens_e;

  // Bit position of each external line's select inside its configuration word.
  function automatic int sel_bit_pos(input int line);
    case (line)
      0:       return 0;
      1:       return 1;
      2:       return 7;
      default: return 8;
    endcase
  endfunction

  // Lines 0 and 1 read word A, lines 2 and 3 read word B.
  function automatic bit sel_in_word_b(input int line);
    return line >= 2;
  endfunction

endpackage

// File: rtl/dmarq_sync.sv
module dmarq_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  localparam int LAST = STAGES - 1;

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= {W{RST_VAL}};
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[LAST];

  generate
    if (STAGES >= 2) begin : g_chk
      // R3: the synchronized value only changes to what the previous stage held
      assert_sync_chain_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stage_q[LAST] != $past(stage_q[LAST])) |-> (stage_q[LAST] == $past(stage_q[LAST-1])));
    end
  endgenerate

endmodule

// File: rtl/dmarq_cfg_decode.sv
module dmarq_cfg_decode
  import dmarq_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CFG_W-1:0]   cfg_a_i,
  input  logic [CFG_W-1:0]   cfg_b_i,
  output logic [NUM_EXT-1:0] mode_o
);

  generate
    for (genvar g = 0; g < NUM_EXT; g++) begin : g_line
      localparam int POS = sel_bit_pos(g);
      if (sel_in_word_b(g)) begin : g_b
        assign mode_o[g] = cfg_b_i[POS];
      end else begin : g_a
        assign mode_o[g] = cfg_a_i[POS];
      end
    end
  endgenerate

  // R2: configuration words are fully defined once out of reset
  assert_cfg_known_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({cfg_a_i, cfg_b_i}));

endmodule

// File: rtl/dmarq_chan.sv
module dmarq_chan
  import dmarq_pkg::*;
#(
  parameter logic RST_MODE = SENS_LEVEL
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic asserted_i,
  input  logic mode_i,
  input  logic ack_i,
  output logic req_o,
  output logic pend_o
);

  logic asserted_q;
  logic mode_q;
  logic pend_q, pend_d;
  logic req_q, req_d;
  logic edge_hit;
  logic mode_chg;

  assign edge_hit = asserted_i & ~asserted_q;
  assign mode_chg = (mode_i != mode_q);

  always_comb begin
    if (mode_chg) begin
      pend_d = 1'b0;
    end else if (mode_i == SENS_EDGE) begin
      pend_d = edge_hit | (pend_q & ~ack_i);
    end else begin
      pend_d = 1'b0;
    end
    req_d = (mode_i == SENS_EDGE) ? pend_d : asserted_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asserted_q <= 1'b0;
      mode_q     <= RST_MODE;
      pend_q     <= 1'b0;
      req_q      <= 1'b0;
    end else begin
      asserted_q <= asserted_i;
      mode_q     <= mode_i;
      pend_q     <= pend_d;
      req_q      <= req_d;
    end
  end

  assign req_o  = req_q;
  assign pend_o = pend_q;

  // R3: level scheme output follows the conditioned input one edge later
  assert_level_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENS_LEVEL) |=> (req_o == $past(asserted_i)));

  // R4: a captured request persists while unacknowledged
  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && mode_i == SENS_EDGE && !mode_chg && !ack_i) |=> pend_o);

  // R5: acknowledge without a fresh edge clears the capture
  assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENS_EDGE && !mode_chg && ack_i && !edge_hit) |=> !pend_o);

  // R5: a fresh edge wins over a simultaneous acknowledge
  assert_edge_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENS_EDGE && !mode_chg && edge_hit) |=> (pend_o && req_o));

  // R6: pending only ever exists under the edge scheme
  assert_pend_edge_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> (mode_q == SENS_EDGE));

  // R7: changing the scheme discards any capture
  assert_mode_change_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> !pend_o);

  // R5: acknowledge is a single-cycle pulse
  assert_ack_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !ack_i);

endmodule

// File: rtl/dmarq_capture.sv
module dmarq_capture
  import dmarq_pkg::*;
#(
  parameter int CFG_W       = 16,
  parameter int NUM_INT     = 3,
  parameter int DISP_IDX    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         ext_req_ni,
  input  logic [CFG_W-1:0]   sens_cfg_a_i,
  input  logic [CFG_W-1:0]   sens_cfg_b_i,
  input  logic [3:0]         ext_ack_i,
  input  logic [NUM_INT-1:0] int_req_i,
  input  logic [NUM_INT-1:0] int_ack_i,
  output logic [3:0]         ext_req_o,
  output logic [3:0]         ext_pend_o,
  output logic [NUM_INT-1:0] int_req_o,
  output logic [NUM_INT-1:0] int_pend_o
);

  localparam logic [NUM_INT-1:0] INT_EDGE_MASK = NUM_INT'(1) << DISP_IDX;

  logic [NUM_EXT-1:0] ext_sync;
  logic [NUM_EXT-1:0] ext_mode;

  dmarq_sync #(
    .W       (NUM_EXT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_req_ni),
    .sync_o  (ext_sync)
  );

  dmarq_cfg_decode #(
    .CFG_W (CFG_W)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_a_i (sens_cfg_a_i),
    .cfg_b_i (sens_cfg_b_i),
    .mode_o  (ext_mode)
  );

  generate
    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
      dmarq_chan #(
        .RST_MODE (SENS_LEVEL)
      ) u_chan (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .asserted_i (~ext_sync[e]),
        .mode_i     (ext_mode[e]),
        .ack_i      (ext_ack_i[e]),
        .req_o      (ext_req_o[e]),
        .pend_o     (ext_pend_o[e])
      );
    end

    for (genvar n = 0; n < NUM_INT; n++) begin : g_int
      dmarq_chan #(
        .RST_MODE (INT_EDGE_MASK[n])
      ) u_chan (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .asserted_i (int_req_i[n]),
        .mode_i     (INT_EDGE_MASK[n]),
        .ack_i      (int_ack_i[n]),
        .req_o      (int_req_o[n]),
        .pend_o     (int_pend_o[n])
      );
    end
  endgenerate

  // R8: fixed level internal lines never report a pending capture
  assert_int_level_no_pend_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_pend_o & ~INT_EDGE_MASK) == '0);

  // R1: just after reset release, all outputs are idle
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (ext_req_o == '0 && ext_pend_o == '0 && int_req_o == '0 && int_pend_o == '0));

endmodule

// File: tb/dmarq_capture_tb.sv
`timescale 1ns/1ps
module dmarq_capture_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pin_n = 4'hF;
  logic [15:0] cfg_a = '0;
  logic [15:0] cfg_b = '0;
  logic [3:0]  ext_ack = '0;
  logic [2:0]  int_req = '0;
  logic [2:0]  int_ack = '0;
  logic [3:0]  ext_req_o, ext_pend_o;
  logic [2:0]  int_req_o, int_pend_o;

  always #4 clk = ~clk;

  dmarq_capture u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ext_req_ni   (pin_n),
    .sens_cfg_a_i (cfg_a),
    .sens_cfg_b_i (cfg_b),
    .ext_ack_i    (ext_ack),
    .int_req_i    (int_req),
    .int_ack_i    (int_ack),
    .ext_req_o    (ext_req_o),
    .ext_pend_o   (ext_pend_o),
    .int_req_o    (int_req_o),
    .int_pend_o   (int_pend_o)
  );

  typedef struct {
    int         cyc;
    int         sel;
    logic [3:0] val;
    string      tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;

  function automatic logic [3:0] field(input int sel);
    case (sel)
      0:       return ext_req_o;
      1:       return ext_pend_o;
      2:       return {1'b0, int_req_o};
      default: return {1'b0, int_pend_o};
    endcase
  endfunction

  // sel: 0 ext_req, 1 ext_pend, 2 int_req, 3 int_pend
  task automatic expect_f(input int dly, input int sel, input logic [3:0] val, input string tag);
    item_t it;
    it.cyc = cyc + dly;
    it.sel = sel;
    it.val = val;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops items due this cycle, compares 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].cyc == cyc) begin
          logic [3:0] act;
          act = field(q[i].sel);
          n_cmp++;
          if (act !== q[i].val) begin
            n_bad++;
            $display("FAIL %s: cycle %0d field %0d actual %b expected %b",
                     q[i].tag, cyc, q[i].sel, act, q[i].val);
          end
          q.delete(i);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Driver
  initial begin
    tick(3);
    rst_n = 1'b1;
    expect_f(1, 0, 4'b0000, "R1");
    expect_f(1, 1, 4'b0000, "R1");
    expect_f(1, 2, 4'b0000, "R1");
    expect_f(1, 3, 4'b0000, "R1");
    tick(2);

    // R3 level scheme on line 0
    pin_n[0] = 1'b0;
    expect_f(2, 0, 4'b0000, "R3 latency");
    expect_f(3, 0, 4'b0001, "R3");
    expect_f(3, 1, 4'b0000, "R3");
    tick(5);
    // R6 acknowledge ignored in level scheme
    ext_ack = 4'b0001;
    expect_f(1, 0, 4'b0001, "R6");
    expect_f(1, 1, 4'b0000, "R6");
    tick(1);
    ext_ack = '0;
    tick(1);
    pin_n[0] = 1'b1;
    expect_f(3, 0, 4'b0000, "R3 release");
    tick(5);

    // R2 positions: line2 edge via word B bit7, junk bits elsewhere
    cfg_a = 16'hFFFC;
    cfg_b = 16'h7E80;
    tick(3);
    pin_n = 4'b0011;
    expect_f(3, 0, 4'b1100, "R2");
    expect_f(3, 1, 4'b0100, "R2 R4");
    tick(4);
    pin_n = 4'b1111;
    expect_f(3, 0, 4'b0100, "R4 sticky");
    expect_f(3, 1, 4'b0100, "R4 sticky");
    tick(6);
    ext_ack = 4'b0100;
    expect_f(1, 1, 4'b0000, "R5 ack");
    expect_f(1, 0, 4'b0000, "R5 ack");
    tick(1);
    ext_ack = '0;
    tick(4);

    // R5 collision of new edge and acknowledge
    pin_n[2] = 1'b0;
    expect_f(3, 1, 4'b0100, "R4");
    tick(2);
    pin_n[2] = 1'b1;
    tick(4);
    pin_n[2] = 1'b0;
    tick(2);
    ext_ack = 4'b0100;
    expect_f(1, 1, 4'b0100, "R5 edge wins");
    expect_f(2, 1, 4'b0100, "R5 edge wins");
    tick(1);
    ext_ack = '0;

    // R10 held-low pin after acknowledge
    tick(2);
    ext_ack = 4'b0100;
    expect_f(1, 1, 4'b0000, "R10");
    tick(1);
    ext_ack = '0;
    expect_f(3, 1, 4'b0000, "R10 held low");
    expect_f(3, 0, 4'b0000, "R10 held low");
    tick(4);
    pin_n[2] = 1'b1;
    tick(4);

    // R7 mode change clears a pending capture on line 3
    cfg_b = 16'h7F80;
    tick(2);
    pin_n[3] = 1'b0;
    expect_f(3, 1, 4'b1000, "R2 R4 line3");
    tick(4);
    pin_n[3] = 1'b1;
    tick(4);
    cfg_b = 16'h7E80;
    expect_f(1, 1, 4'b0000, "R7 clear");
    expect_f(1, 0, 4'b0000, "R7 clear");
    tick(4);
    pin_n[3] = 1'b0;
    expect_f(3, 0, 4'b1000, "R3 line3");
    tick(4);
    cfg_b = 16'h7F80;
    expect_f(1, 0, 4'b0000, "R7 switch drops");
    expect_f(1, 1, 4'b0000, "R7 switch drops");
    expect_f(4, 1, 4'b0000, "R7 no capture");
    tick(4);
    pin_n[3] = 1'b1;
    tick(4);

    // R2 line 0 edge via word A bit0
    cfg_a = 16'hFFFD;
    tick(2);
    pin_n[0] = 1'b0;
    expect_f(3, 1, 4'b0001, "R2 line0");
    tick(4);
    pin_n[0] = 1'b1;
    tick(4);

    // R8 internal level line
    int_req = 3'b001;
    expect_f(1, 2, 4'b0001, "R8");
    expect_f(1, 3, 4'b0000, "R8");
    tick(2);
    int_ack = 3'b001;
    expect_f(1, 2, 4'b0001, "R8 ack ignored");
    tick(1);
    int_ack = '0;
    int_req = '0;
    expect_f(1, 2, 4'b0000, "R8 release");
    tick(2);

    // R9 display line-trigger edge line
    int_req = 3'b100;
    expect_f(1, 3, 4'b0100, "R9");
    expect_f(1, 2, 4'b0100, "R9");
    tick(1);
    int_req = '0;
    expect_f(1, 3, 4'b0100, "R9 sticky");
    tick(3);
    int_ack = 3'b100;
    expect_f(1, 3, 4'b0000, "R9 ack");
    expect_f(1, 2, 4'b0000, "R9 ack");
    tick(1);
    int_ack = '0;
    tick(4);

    while (q.size() != 0) tick(1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule